// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the address engine of one DMA channel. Software fills a small byte-wide register image with a 24-bit source address, a 24-bit destination address, an inner transfer count, an outer transfer count and a control byte. The control byte selects an addressing mode and a transfer data size. A one-cycle `start` pulse copies the image into the working state. After that, every cycle in which `req` is high produces one transfer descriptor: a source address, a destination address and a size code. The external bus engine, which is not part of this block, carries out the transfer.

After each descriptor the working source and destination addresses move by the data size in bytes: up, down or not at all, depending on the mode. The inner count then steps, and the outer count steps each time the inner count is used up. The descriptor that ends the run carries a one-cycle `done` pulse. A reserved mode or size is refused when `start` arrives. Register writes during a run change only the image, so they apply from the next `start`.

Top module: `dma_addr_seq`

## Requirements
- R1: After synchronous reset every register offset reads 0, and `busy`, `xfer_valid`, `done` and `err` are 0.
- R2: The register map is as follows. Offsets 0..2 hold the source address and offsets 3..5 the destination address, least significant byte first. Offsets 6..7 hold the inner count and 8..9 the outer count, low byte first. Offset 10 is control, with the size code in bits [1:0], the mode code in bits [4:2], and bits [7:5] reading 0. Writes to any other offset are ignored and reads from it return 0. `reg_rdata` is combinational on `reg_addr`.
- R3: When `req` is high at a clock edge while `busy` is high, `xfer_valid` is high in the next cycle. It carries the working addresses from before that edge, with `xfer_size` equal to the size code. `req` has no effect while `busy` is low.
- R4: Mode codes set the direction of each address. Code 0 moves the destination up and code 1 moves it down; in both the source holds. Code 2 moves the source up and code 3 moves it down; in both the destination holds. Code 4 moves both up, code 5 moves both down, and code 6 holds both.
- R5: A moving address changes by 1, 2 or 4 bytes for size codes 0, 1 and 2, and wraps modulo 2^24.
- R6: Every descriptor decrements the inner count. When the inner count reaches zero and the outer count is nonzero, the inner count reloads its programmed value and the outer count decrements. A run therefore issues inner×(outer+1) descriptors.
- R7: `done` is high for exactly one cycle, together with the final descriptor, and `busy` is low in that same cycle.
- R8: A `start` pulse with mode code 7 or size code 3 sets `err`, leaves `busy` low and produces no descriptors. The next `start` that is accepted clears `err`.
- R9: A register write while `busy` is high shows at once in the readback. It does not change the descriptors of the current run, and it is used from the next `start`.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| start | input | 1 | Load the image and arm the channel |
| req | input | 1 | Transfer request |
| busy | output | 1 | Channel run in progress |
| xfer_valid | output | 1 | Descriptor valid this cycle |
| xfer_src | output | 24 | Descriptor source address |
| xfer_dst | output | 24 | Descriptor destination address |
| xfer_size | output | 2 | Descriptor size code |
| done | output | 1 | Final descriptor of the run |
| err | output | 1 | Last start refused for a reserved setting |

## Verification
On every cycle the assertions check the following. A descriptor only follows a request made while busy, and every such request yields one. Within a run, consecutive source and destination addresses differ by zero or exactly one size step. `done` only comes with a descriptor and with `busy` low. A refusal never leaves the channel busy, and a reserved size code never reaches a descriptor. Only the bench's scenarios can show the rest: the exact direction for each mode, the wrap at the 24-bit boundary, the number of descriptors produced by the cascaded counts, the register map, and the deferral of writes made during a run.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        M_DST_INC   = 3'd0,
        M_DST_DEC   = 3'd1,
        M_SRC_INC   = 3'd2,
        M_SRC_DEC   = 3'd3,
        M_BOTH_INC  = 3'd4,
        M_BOTH_DEC  = 3'd5,
        M_BOTH_HOLD = 3'd6,
        M_RSVD      = 3'd7
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SZ_1    = 2'd0,
        SZ_2    = 2'd1,
        SZ_4    = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_dir_e;

    // packed order matches the control byte: mode in [4:2], size in [1:0]
    typedef struct packed {
        xfer_mode_e mode;
        xfer_size_e size;
    } chan_cfg_t;

    function automatic step_dir_e side_dir(xfer_mode_e m, logic is_src);
        step_dir_e d;
        case (m)
            M_DST_INC:  d = is_src ? STEP_HOLD : STEP_INC;
            M_DST_DEC:  d = is_src ? STEP_HOLD : STEP_DEC;
            M_SRC_INC:  d = is_src ? STEP_INC  : STEP_HOLD;
            M_SRC_DEC:  d = is_src ? STEP_DEC  : STEP_HOLD;
            M_BOTH_INC: d = STEP_INC;
            M_BOTH_DEC: d = STEP_DEC;
            default:    d = STEP_HOLD;
        endcase
        return d;
    endfunction

    function automatic logic [2:0] size_bytes(xfer_size_e s);
        logic [2:0] b;
        case (s)
            SZ_1:    b = 3'd1;
            SZ_2:    b = 3'd2;
            SZ_4:    b = 3'd4;
            default: b = 3'd0;
        endcase
        return b;
    endfunction

    function automatic logic cfg_reserved(chan_cfg_t c);
        return (c.mode == M_RSVD) || (c.size == SZ_RSVD);
    endfunction

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int AW  = 24,
    parameter int CW  = 16,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    output logic [AW-1:0]  src_img,
    output logic [AW-1:0]  dst_img,
    output logic [CW-1:0]  ca_img,
    output logic [CW-1:0]  cb_img,
    output chan_cfg_t      cfg_img
);
    localparam int AB      = AW / 8;
    localparam int CB      = CW / 8;
    localparam int SRC_OFS = 0;
    localparam int DST_OFS = AB;
    localparam int CA_OFS  = 2 * AB;
    localparam int CB_OFS  = 2 * AB + CB;
    localparam int CTL_OFS = 2 * AB + 2 * CB;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_img <= '0;
            dst_img <= '0;
            ca_img  <= '0;
            cb_img  <= '0;
            cfg_img <= '{mode: M_DST_INC, size: SZ_1};
        end else if (we) begin
            for (int i = 0; i < AB; i++) begin
                if (addr == RAW'(SRC_OFS + i)) src_img[8*i +: 8] <= wdata;
                if (addr == RAW'(DST_OFS + i)) dst_img[8*i +: 8] <= wdata;
            end
            for (int i = 0; i < CB; i++) begin
                if (addr == RAW'(CA_OFS + i)) ca_img[8*i +: 8] <= wdata;
                if (addr == RAW'(CB_OFS + i)) cb_img[8*i +: 8] <= wdata;
            end
            if (addr == RAW'(CTL_OFS))
                cfg_img <= '{mode: xfer_mode_e'(wdata[4:2]), size: xfer_size_e'(wdata[1:0])};
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < AB; i++) begin
            if (addr == RAW'(SRC_OFS + i)) rdata = src_img[8*i +: 8];
            if (addr == RAW'(DST_OFS + i)) rdata = dst_img[8*i +: 8];
        end
        for (int i = 0; i < CB; i++) begin
            if (addr == RAW'(CA_OFS + i)) rdata = ca_img[8*i +: 8];
            if (addr == RAW'(CB_OFS + i)) rdata = cb_img[8*i +: 8];
        end
        if (addr == RAW'(CTL_OFS)) rdata = {3'b000, cfg_img};
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr,
    input  step_dir_e     dir,
    input  xfer_size_e    size,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] step;

    always_comb begin
        step = AW'(size_bytes(size));
        case (dir)
            STEP_INC: nxt = addr + step;
            STEP_DEC: nxt = addr - step;
            default:  nxt = addr;
        endcase
    end
endmodule

// File: rtl/dma_cnt_cascade.sv
module dma_cnt_cascade #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] a_init,
    input  logic [CW-1:0] b_init,
    input  logic          step,
    output logic          last
);
    logic [CW-1:0] cnt_a;
    logic [CW-1:0] cnt_b;
    logic [CW-1:0] reload_a;
    logic [CW-1:0] a_dec;

    assign a_dec = cnt_a - CW'(1);
    assign last  = (a_dec == '0) && (cnt_b == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_a    <= '0;
            cnt_b    <= '0;
            reload_a <= '0;
        end else if (load) begin
            cnt_a    <= a_init;
            cnt_b    <= b_init;
            reload_a <= a_init;
        end else if (step) begin
            if (a_dec != '0) begin
                cnt_a <= a_dec;
            end else if (cnt_b != '0) begin
                cnt_a <= reload_a;
                cnt_b <= cnt_b - CW'(1);
            end else begin
                cnt_a <= '0;
            end
        end
    end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
    import dma_seq_pkg::*;
#(
    parameter int AW  = 24,
    parameter int CW  = 16,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic           start,
    input  logic           req,
    output logic           busy,
    output logic           xfer_valid,
    output logic [AW-1:0]  xfer_src,
    output logic [AW-1:0]  xfer_dst,
    output logic [1:0]     xfer_size,
    output logic           done,
    output logic           err
);
    localparam int NSIDE = 2;

    logic [AW-1:0] src_img, dst_img;
    logic [CW-1:0] ca_img, cb_img;
    chan_cfg_t     cfg_img;
    chan_cfg_t     cfg_run;
    logic          active;
    logic [AW-1:0] side_cur [NSIDE];
    logic [AW-1:0] side_nxt [NSIDE];
    logic          start_ok, cfg_bad, fire, cnt_last;

    dma_seq_regs #(.AW(AW), .CW(CW), .RAW(RAW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .src_img (src_img),
        .dst_img (dst_img),
        .ca_img  (ca_img),
        .cb_img  (cb_img),
        .cfg_img (cfg_img)
    );

    assign start_ok = start && !active;
    assign cfg_bad  = cfg_reserved(cfg_img);
    assign fire     = active && req;

    // side 0 is the source, side 1 the destination
    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_step #(.AW(AW)) u_step (
            .addr (side_cur[g]),
            .dir  (side_dir(cfg_run.mode, g == 0)),
            .size (cfg_run.size),
            .nxt  (side_nxt[g])
        );
    end

    dma_cnt_cascade #(.CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (start_ok && !cfg_bad),
        .a_init (ca_img),
        .b_init (cb_img),
        .step   (fire),
        .last   (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            err         <= 1'b0;
            done        <= 1'b0;
            xfer_valid  <= 1'b0;
            xfer_src    <= '0;
            xfer_dst    <= '0;
            xfer_size   <= '0;
            cfg_run     <= '{mode: M_DST_INC, size: SZ_1};
            side_cur[0] <= '0;
            side_cur[1] <= '0;
        end else begin
            xfer_valid <= 1'b0;
            done       <= 1'b0;
            if (start_ok) begin
                if (cfg_bad) begin
                    err <= 1'b1;
                end else begin
                    err         <= 1'b0;
                    active      <= 1'b1;
                    cfg_run     <= cfg_img;
                    side_cur[0] <= src_img;
                    side_cur[1] <= dst_img;
                end
            end else if (fire) begin
                xfer_valid  <= 1'b1;
                xfer_src    <= side_cur[0];
                xfer_dst    <= side_cur[1];
                xfer_size   <= cfg_run.size;
                side_cur[0] <= side_nxt[0];
                side_cur[1] <= side_nxt[1];
                if (cnt_last) begin
                    done   <= 1'b1;
                    active <= 1'b0;
                end
            end
        end
    end

    assign busy = active;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          req,
    input logic          busy,
    input logic          xfer_valid,
    input logic [AW-1:0] xfer_src,
    input logic [AW-1:0] xfer_dst,
    input logic [1:0]    xfer_size,
    input logic          done,
    input logic          err
);
    logic          seen;
    logic [AW-1:0] psrc, pdst;
    logic [AW-1:0] stepv;

    assign stepv = AW'(1) << xfer_size;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            psrc <= '0;
            pdst <= '0;
        end else if (start && !busy) begin
            seen <= 1'b0;
        end else if (xfer_valid) begin
            seen <= 1'b1;
            psrc <= xfer_src;
            pdst <= xfer_dst;
        end
    end

    a_r3_req_gives_desc: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> xfer_valid);
    a_r3_desc_needs_req: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> $past(req) && $past(busy));
    a_r5_src_delta: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && seen) |->
            (xfer_src == psrc || xfer_src == psrc + stepv || xfer_src == psrc - stepv));
    a_r5_dst_delta: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && seen) |->
            (xfer_dst == pdst || xfer_dst == pdst + stepv || xfer_dst == pdst - stepv));
    a_r7_done_with_desc: assert property (@(posedge clk) disable iff (rst)
        done |-> xfer_valid && !busy);
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_err_not_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy);
    a_r8_no_rsvd_size: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> xfer_size != 2'b11);
endmodule

bind dma_addr_seq dma_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dma_addr_seq.sv
module sim_dma_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  size;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [23:0] src;
        logic [23:0] dst;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd0, 16'd3, 16'd0, 24'h100000, 24'h000010},
        '{3'd1, 2'd1, 16'd2, 16'd1, 24'h000040, 24'h000008},
        '{3'd2, 2'd2, 16'd3, 16'd0, 24'hFFFFF8, 24'h300000},
        '{3'd3, 2'd0, 16'd1, 16'd2, 24'h000001, 24'h000055},
        '{3'd4, 2'd1, 16'd2, 16'd2, 24'h001000, 24'h002000},
        '{3'd5, 2'd2, 16'd3, 16'd0, 24'h000010, 24'h000020},
        '{3'd6, 2'd0, 16'd2, 16'd1, 24'h123456, 24'h654321}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        start = 1'b0;
    logic        req = 1'b0;
    logic        busy, xfer_valid, done, err;
    logic [23:0] xfer_src, xfer_dst;
    logic [1:0]  xfer_size;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_seq u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic program_chan(vec_t v);
        for (int i = 0; i < 3; i++) wr(4'(i), v.src[8*i +: 8]);
        for (int i = 0; i < 3; i++) wr(4'(3 + i), v.dst[8*i +: 8]);
        for (int i = 0; i < 2; i++) wr(4'(6 + i), v.ca[8*i +: 8]);
        for (int i = 0; i < 2; i++) wr(4'(8 + i), v.cb[8*i +: 8]);
        wr(4'd10, {3'b000, v.mode, v.size});
    endtask

    function automatic int dir_of(logic [2:0] m, bit is_src);
        case (m)
            3'd0: return is_src ? 0 : 1;
            3'd1: return is_src ? 0 : -1;
            3'd2: return is_src ? 1 : 0;
            3'd3: return is_src ? -1 : 0;
            3'd4: return 1;
            3'd5: return -1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [23:0] exp_addr(logic [23:0] base, int dir, int stp, int k);
        return base + 24'(dir * stp * k);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 11; i++) begin
            rd(4'(i), d);
            check($sformatf("R1 reg%0d", i), 32'(d), 0);
        end
        check("R1 busy", 32'(busy), 0);
        check("R1 valid", 32'(xfer_valid), 0);
        check("R1 done", 32'(done), 0);
        check("R1 err", 32'(err), 0);

        // R2 map: unmapped offset ignored, control upper bits read 0
        wr(4'd12, 8'hA5);
        rd(4'd12, d); check("R2 unmapped read", 32'(d), 0);
        wr(4'd10, 8'hFF);
        rd(4'd10, d); check("R2 ctrl mask", 32'(d), 32'h1F);
        wr(4'd10, 8'h00);

        // R3 request while idle ignored
        do_req();
        check("R3 idle req no desc", 32'(xfer_valid), 0);

        // vector table: R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            int n, sd, dd, stp;
            program_chan(VECS[v]);
            rd(4'd1, d); check("R2 src byte1", 32'(d), 32'(VECS[v].src[15:8]));
            rd(4'd5, d); check("R2 dst byte2", 32'(d), 32'(VECS[v].dst[23:16]));
            pulse_start();
            check("R8 busy after start", 32'(busy), 1);
            n   = int'(VECS[v].ca) * (int'(VECS[v].cb) + 1);
            sd  = dir_of(VECS[v].mode, 1'b1);
            dd  = dir_of(VECS[v].mode, 1'b0);
            stp = 1 << VECS[v].size;
            for (int k = 0; k < n; k++) begin
                if (k % 2 == 1) @(negedge clk);
                do_req();
                check($sformatf("R3 v%0d k%0d valid", v, k), 32'(xfer_valid), 1);
                check($sformatf("R4 R5 v%0d k%0d src", v, k), 32'(xfer_src),
                      32'(exp_addr(VECS[v].src, sd, stp, k)));
                check($sformatf("R4 R5 v%0d k%0d dst", v, k), 32'(xfer_dst),
                      32'(exp_addr(VECS[v].dst, dd, stp, k)));
                check($sformatf("R3 v%0d size", v), 32'(xfer_size), 32'(VECS[v].size));
                check($sformatf("R6 R7 v%0d k%0d done", v, k), 32'(done),
                      32'(k == n - 1));
            end
            check($sformatf("R7 v%0d busy clear", v), 32'(busy), 0);
            @(negedge clk);
            check($sformatf("R7 v%0d done one cycle", v), 32'(done), 0);
        end

        // R8 reserved mode and size
        program_chan('{3'd7, 2'd0, 16'd1, 16'd0, 24'h000100, 24'h000200});
        pulse_start();
        check("R8 rsvd mode err", 32'(err), 1);
        check("R8 rsvd mode busy", 32'(busy), 0);
        do_req();
        check("R8 rsvd mode no desc", 32'(xfer_valid), 0);
        wr(4'd10, {3'b000, 3'd0, 2'd3});
        pulse_start();
        check("R8 rsvd size err", 32'(err), 1);
        check("R8 rsvd size busy", 32'(busy), 0);

        // R9 R10 writes and start during a run
        program_chan('{3'd4, 2'd0, 16'd3, 16'd0, 24'h000100, 24'h000200});
        pulse_start();
        check("R8 err cleared", 32'(err), 0);
        do_req();
        check("R9 first src", 32'(xfer_src), 32'h100);
        wr(4'd0, 8'hEE);
        pulse_start();
        do_req();
        check("R9 R10 src unaffected", 32'(xfer_src), 32'h101);
        check("R10 dst unaffected", 32'(xfer_dst), 32'h201);
        check("R10 not done", 32'(done), 0);
        rd(4'd0, d);
        check("R9 readback new", 32'(d), 32'hEE);
        do_req();
        check("R9 src third", 32'(xfer_src), 32'h102);
        check("R6 done after three", 32'(done), 1);
        pulse_start();
        do_req();
        check("R9 new value used", 32'(xfer_src), 32'h0001EE);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule